// File: doc/BRIEF.md
# Dual-Mode Configurable Multiplier Core

This block is a multiplier datapath that works either as one full-width multiplier (16 by 16 bits, 32-bit product) or as a pair of independent half-width multipliers (8 by 8 bits each, 16-bit products). The operand buses `a_in` and `b_in` each pass through an input stage that can be built as a register or as a wire. A built register has a hold control. The products then pass through optional pipeline stages. The half products are always available on their own ports. The 32-bit product port carries either the full product or the two half products packed side by side, depending on the `MODE` parameter.

Parameters choose the signedness of each operand, which stages exist, and whether the block clocks on the rising or the falling edge. The default build has no registers, unsigned operands and rising-edge clocking. With that build the block is a pure combinational multiplier. A single clock enable gates every register. Two synchronous, active-high resets clear separate halves of the pipeline.

Top module: `dual_mul_core`

## Requirements
- R1: In wide mode (`MODE` = `MODE_WIDE`), `prod_o` equals `a_in` times `b_in`, truncated to 32 bits, once the enabled stages have been passed.
- R2: In split mode (`MODE` = `MODE_SPLIT`), `prod_o[31:16]` equals `prod_hi_o` and `prod_o[15:0]` equals `prod_lo_o`. In both modes `prod_hi_o` is `a_in[15:8]` times `b_in[15:8]` and `prod_lo_o` is `a_in[7:0]` times `b_in[7:0]`, and neither half depends on the other half's operand bits.
- R3: `A_SIGNED` and `B_SIGNED` each make one operand two's complement, independently of the other, so mixed-sign products are supported. Bit 15 is the sign of a full operand and of an upper half. Bit 7 is the sign of a lower half.
- R4: When an operand input register is built, `hold_a` or `hold_b` set to 1 keeps the stored operand, and 0 loads the port value at the next active edge.
- R5: Latency equals the number of built stages on the path. The full product path has up to three stages (operand, intermediate, final). Each half product path has up to two (operand, half product).
- R6: With `ce` at 0, no register changes, so every output holds its value while the inputs change.
- R7: `rst_top` clears the A operand register and the upper half-product register. `rst_bot` clears the B operand register, the lower half-product register and both full-product registers. A reset acts at the active edge even when `ce` is 0 or a hold is set.
- R8: With default parameters the block is combinational and unsigned, so outputs follow inputs in the same cycle.
- R9: With `NEG_EDGE` set to 1, every register updates on the falling edge of `clk` and not on the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; active edge chosen by `NEG_EDGE` |
| ce | input | 1 | Clock enable for every register |
| rst_top | input | 1 | Synchronous clear of the A register and the upper half-product register |
| rst_bot | input | 1 | Synchronous clear of the B register, the lower half-product register and the full-product registers |
| hold_a | input | 1 | 1 keeps the A operand register, 0 loads it |
| hold_b | input | 1 | 1 keeps the B operand register, 0 loads it |
| a_in | input | 16 | Operand A |
| b_in | input | 16 | Operand B |
| prod_o | output | 32 | Full product, or the packed half products in split mode |
| prod_hi_o | output | 16 | Upper half product |
| prod_lo_o | output | 16 | Lower half product |

## Verification
The hardest case to reach from the ports is a set of registers holding operands from different moments: an A register that is held while B keeps loading, or a reset that clears one half while the other half and the full-product path carry on. The stimulus first fills the fully registered pipeline with a known pair. It then changes the inputs while asserting a hold, deasserting `ce` or pulsing one reset. Each output is read on the exact edge where the stage count says it moves, and the bench checks that the unaffected half still shows its old product. A separate falling-edge instance is sampled between the two clock edges to show which edge captured the data.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
    typedef enum logic {
        MODE_WIDE  = 1'b0,
        MODE_SPLIT = 1'b1
    } dmc_mode_e;

    localparam int unsigned DMC_HALF_W = 8;
endpackage

// File: rtl/dmc_stage.sv
module dmc_stage #(
    parameter int unsigned WIDTH   = 16,
    parameter bit          PRESENT = 1'b0
) (
    input  logic             clk,
    input  logic             ce,
    input  logic             rst,
    input  logic             hold,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    generate
        if (PRESENT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    q <= '0;
                else if (ce && !hold)
                    q <= d;
            end

            AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
                (!ce || hold) |=> $stable(q)) else $error("hold/ce broke");  // R4
            AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
                (ce && !hold) |=> (q == $past(d))) else $error("load lost");  // R5
            AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
                $fell(rst) |-> (q == '0)) else $error("reset missed");  // R7
        end else begin : g_wire
            logic unused_ctl;
            assign q          = d;
            assign unused_ctl = ^{clk, ce, rst, hold};
        end
    endgenerate
endmodule

// File: rtl/dmc_mul.sv
module dmc_mul #(
    parameter int unsigned W     = 8,
    parameter bit          A_SGN = 1'b0,
    parameter bit          B_SGN = 1'b0
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int unsigned EW = W + 1;

    logic signed [EW-1:0]   a_ext;
    logic signed [EW-1:0]   b_ext;
    logic signed [2*EW-1:0] mul_full;
    logic                   unused_hi;

    assign a_ext     = $signed({A_SGN & a[W-1], a});
    assign b_ext     = $signed({B_SGN & b[W-1], b});
    assign mul_full  = a_ext * b_ext;
    assign p         = mul_full[2*W-1:0];
    assign unused_hi = ^mul_full[2*EW-1:2*W];

    always_comb begin
        if (a == '0 || b == '0)
            AST_ZERO_ANNIHILATES: assert (p == '0) else $error("zero operand gave nonzero product");  // R1
    end
endmodule

// File: rtl/dual_mul_core.sv
module dual_mul_core
    import dmc_pkg::*;
#(
    parameter int unsigned HALF_W     = DMC_HALF_W,
    parameter dmc_mode_e   MODE       = MODE_WIDE,
    parameter bit          A_SIGNED   = 1'b0,
    parameter bit          B_SIGNED   = 1'b0,
    parameter bit          A_IN_REG   = 1'b0,
    parameter bit          B_IN_REG   = 1'b0,
    parameter bit          HI_REG     = 1'b0,
    parameter bit          LO_REG     = 1'b0,
    parameter bit          WIDE_MID_REG = 1'b0,
    parameter bit          WIDE_OUT_REG = 1'b0,
    parameter bit          NEG_EDGE   = 1'b0,
    localparam int unsigned FULL_W    = 2 * HALF_W,
    localparam int unsigned PROD_W    = 2 * FULL_W
) (
    input  logic              clk,
    input  logic              ce,
    input  logic              rst_top,
    input  logic              rst_bot,
    input  logic              hold_a,
    input  logic              hold_b,
    input  logic [FULL_W-1:0] a_in,
    input  logic [FULL_W-1:0] b_in,
    output logic [PROD_W-1:0] prod_o,
    output logic [FULL_W-1:0] prod_hi_o,
    output logic [FULL_W-1:0] prod_lo_o
);
    logic              clk_g;
    logic [FULL_W-1:0] a_q;
    logic [FULL_W-1:0] b_q;
    logic [FULL_W-1:0] hi_raw;
    logic [FULL_W-1:0] lo_raw;
    logic [PROD_W-1:0] wide_raw;
    logic [PROD_W-1:0] wide_mid;
    logic [PROD_W-1:0] wide_fin;

    assign clk_g = NEG_EDGE ? ~clk : clk;

    // operand stages
    dmc_stage #(.WIDTH(FULL_W), .PRESENT(A_IN_REG)) u_areg (
        .clk(clk_g), .ce(ce), .rst(rst_top), .hold(hold_a), .d(a_in), .q(a_q));
    dmc_stage #(.WIDTH(FULL_W), .PRESENT(B_IN_REG)) u_breg (
        .clk(clk_g), .ce(ce), .rst(rst_bot), .hold(hold_b), .d(b_in), .q(b_q));

    // multiplier arrays
    dmc_mul #(.W(FULL_W), .A_SGN(A_SIGNED), .B_SGN(B_SIGNED)) u_wide (
        .a(a_q), .b(b_q), .p(wide_raw));
    dmc_mul #(.W(HALF_W), .A_SGN(A_SIGNED), .B_SGN(B_SIGNED)) u_hi (
        .a(a_q[FULL_W-1:HALF_W]), .b(b_q[FULL_W-1:HALF_W]), .p(hi_raw));
    dmc_mul #(.W(HALF_W), .A_SGN(A_SIGNED), .B_SGN(B_SIGNED)) u_lo (
        .a(a_q[HALF_W-1:0]), .b(b_q[HALF_W-1:0]), .p(lo_raw));

    // product stages
    dmc_stage #(.WIDTH(FULL_W), .PRESENT(HI_REG)) u_hireg (
        .clk(clk_g), .ce(ce), .rst(rst_top), .hold(1'b0), .d(hi_raw), .q(prod_hi_o));
    dmc_stage #(.WIDTH(FULL_W), .PRESENT(LO_REG)) u_loreg (
        .clk(clk_g), .ce(ce), .rst(rst_bot), .hold(1'b0), .d(lo_raw), .q(prod_lo_o));
    dmc_stage #(.WIDTH(PROD_W), .PRESENT(WIDE_MID_REG)) u_wmid (
        .clk(clk_g), .ce(ce), .rst(rst_bot), .hold(1'b0), .d(wide_raw), .q(wide_mid));
    dmc_stage #(.WIDTH(PROD_W), .PRESENT(WIDE_OUT_REG)) u_wout (
        .clk(clk_g), .ce(ce), .rst(rst_bot), .hold(1'b0), .d(wide_mid), .q(wide_fin));

    generate
        if (MODE == MODE_SPLIT) begin : g_split
            logic [FULL_W-1:0] unused_wide_hi;
            logic [FULL_W-1:0] unused_wide_lo;
            assign prod_o         = {prod_hi_o, prod_lo_o};
            assign unused_wide_hi = wide_fin[PROD_W-1:FULL_W];
            assign unused_wide_lo = wide_fin[FULL_W-1:0];
        end else begin : g_wide
            assign prod_o = wide_fin;
        end
    endgenerate
endmodule

// File: tb/sim_dual_mul_core.sv
module sim_dual_mul_core;
    import dmc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;
    localparam logic [31:0] VEC [NVEC] = '{
        32'h0000_1234, 32'h0001_0001, 32'hFFFF_FFFF, 32'h8000_FFFF,
        32'h7F80_80FF, 32'h1234_5678, 32'h00FF_FF00, 32'h8001_7FFF
    };

    logic        clk = 1'b0;
    logic        ce = 1'b1;
    logic        rst_top = 1'b1;
    logic        rst_bot = 1'b1;
    logic        hold_a = 1'b0;
    logic        hold_b = 1'b0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic [31:0] p0, p1, p2;
    logic [15:0] h0, l0, h1, l1, h2, l2;
    int          checks = 0;
    int          errors = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    // fully registered, A signed, B unsigned, wide mode
    dual_mul_core #(.MODE(MODE_WIDE), .A_SIGNED(1'b1), .B_SIGNED(1'b0),
        .A_IN_REG(1'b1), .B_IN_REG(1'b1), .HI_REG(1'b1), .LO_REG(1'b1),
        .WIDE_MID_REG(1'b1), .WIDE_OUT_REG(1'b1)) u0 (
        .clk(clk), .ce(ce), .rst_top(rst_top), .rst_bot(rst_bot),
        .hold_a(hold_a), .hold_b(hold_b), .a_in(a), .b_in(b),
        .prod_o(p0), .prod_hi_o(h0), .prod_lo_o(l0));

    // defaults, split mode
    dual_mul_core #(.MODE(MODE_SPLIT)) u1 (
        .clk(clk), .ce(1'b1), .rst_top(1'b0), .rst_bot(1'b0),
        .hold_a(1'b0), .hold_b(1'b0), .a_in(a), .b_in(b),
        .prod_o(p1), .prod_hi_o(h1), .prod_lo_o(l1));

    // falling edge, both signed, only A registered
    dual_mul_core #(.A_SIGNED(1'b1), .B_SIGNED(1'b1), .A_IN_REG(1'b1),
        .NEG_EDGE(1'b1)) u2 (
        .clk(clk), .ce(1'b1), .rst_top(rst_top), .rst_bot(rst_bot),
        .hold_a(1'b0), .hold_b(1'b0), .a_in(a), .b_in(b),
        .prod_o(p2), .prod_hi_o(h2), .prod_lo_o(l2));

    function automatic logic [31:0] ref_w(logic [15:0] x, logic [15:0] y, bit sx, bit sy);
        longint vx, vy, r;
        vx = sx ? longint'($signed(x)) : longint'(x);
        vy = sy ? longint'($signed(y)) : longint'(y);
        r = vx * vy;
        return r[31:0];
    endfunction

    function automatic logic [15:0] ref_n(logic [7:0] x, logic [7:0] y, bit sx, bit sy);
        longint vx, vy, r;
        vx = sx ? longint'($signed(x)) : longint'(x);
        vy = sy ? longint'($signed(y)) : longint'(y);
        r = vx * vy;
        return r[15:0];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_u0(string req, logic [15:0] x, logic [15:0] y);
        chk(req, p0, ref_w(x, y, 1'b1, 1'b0));
        chk(req, {16'h0, h0}, {16'h0, ref_n(x[15:8], y[15:8], 1'b1, 1'b0)});
        chk(req, {16'h0, l0}, {16'h0, ref_n(x[7:0], y[7:0], 1'b1, 1'b0)});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] ka, kb, na, nb;
        logic [31:0] fp;
        logic [15:0] fh, fl;
        step();
        step();
        // R7 reset state
        chk("R7 reset prod", p0, 32'h0);
        chk("R7 reset hi", {16'h0, h0}, 32'h0);
        chk("R7 reset lo", {16'h0, l0}, 32'h0);
        rst_top = 1'b0;
        rst_bot = 1'b0;
        step();

        // vector table: R1 R2 R3 R8
        for (int i = 0; i < NVEC; i++) begin
            a = VEC[i][31:16];
            b = VEC[i][15:0];
            #1;
            chk("R8 comb hi", {16'h0, h1}, {16'h0, ref_n(a[15:8], b[15:8], 1'b0, 1'b0)});
            chk("R8 comb lo", {16'h0, l1}, {16'h0, ref_n(a[7:0], b[7:0], 1'b0, 1'b0)});
            chk("R2 split pack", p1, {ref_n(a[15:8], b[15:8], 1'b0, 1'b0),
                                      ref_n(a[7:0], b[7:0], 1'b0, 1'b0)});
            step();
            step();
            step();
            chk_u0("R1 R3 mixed sign", a, b);
            chk("R3 both signed", p2, ref_w(a, b, 1'b1, 1'b1));
        end

        // R5 exact latency: half paths 2 stages, full path 3 stages
        ka = a; kb = b;
        a = 16'hF00D; b = 16'h0BAD;
        step();
        step();
        chk("R5 hi at 2", {16'h0, h0}, {16'h0, ref_n(8'hF0, 8'h0B, 1'b1, 1'b0)});
        chk("R5 lo at 2", {16'h0, l0}, {16'h0, ref_n(8'h0D, 8'hAD, 1'b1, 1'b0)});
        chk("R5 wide not at 2", p0, ref_w(ka, kb, 1'b1, 1'b0));
        step();
        chk("R5 wide at 3", p0, ref_w(16'hF00D, 16'h0BAD, 1'b1, 1'b0));

        // R4 hold A while B loads
        ka = a;
        hold_a = 1'b1;
        a = 16'h1111; b = 16'h0203;
        step(); step(); step();
        chk_u0("R4 hold A", ka, 16'h0203);
        hold_a = 1'b0;
        step(); step(); step();
        chk_u0("R4 release", 16'h1111, 16'h0203);

        // R6 clock enable low freezes outputs
        fp = p0; fh = h0; fl = l0;
        ce = 1'b0;
        na = 16'h5A5A; nb = 16'hA5A5;
        a = na; b = nb;
        step(); step(); step();
        chk("R6 ce prod", p0, fp);
        chk("R6 ce hi", {16'h0, h0}, {16'h0, fh});
        chk("R6 ce lo", {16'h0, l0}, {16'h0, fl});
        ce = 1'b1;
        step(); step(); step();
        chk_u0("R6 resume", na, nb);

        // R7 top reset clears only the upper half
        fl = l0;
        rst_top = 1'b1;
        step();
        rst_top = 1'b0;
        chk("R7 top clears hi", {16'h0, h0}, 32'h0);
        chk("R7 top keeps lo", {16'h0, l0}, {16'h0, fl});
        step(); step(); step();
        chk_u0("R7 recover", na, nb);

        // R7 bottom reset wins over ce low and hold
        fh = h0;
        ce = 1'b0;
        hold_b = 1'b1;
        rst_bot = 1'b1;
        step();
        rst_bot = 1'b0;
        chk("R7 bot clears lo", {16'h0, l0}, 32'h0);
        chk("R7 bot clears prod", p0, 32'h0);
        chk("R7 bot keeps hi", {16'h0, h0}, {16'h0, fh});
        ce = 1'b1;
        hold_b = 1'b0;
        step(); step(); step();
        chk_u0("R7 bot recover", na, nb);

        // R9 falling edge capture on u2
        a = 16'h0300; b = 16'hFFFE;
        step(); step();
        a = 16'h0005;
        #2;
        chk("R9 no rise update", p2, ref_w(16'h0300, 16'hFFFE, 1'b1, 1'b1));
        #(CLK_PERIOD / 2);
        chk("R9 fall update", p2, ref_w(16'h0005, 16'hFFFE, 1'b1, 1'b1));

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule